// File: doc/BRIEF.md
# Display Raster Timing and Status Generator

This block derives the horizontal and vertical scan timing of a small fixed-resolution display from the system clock. A dot counter splits every line into an active drawing span and a horizontal blanking span. A line counter steps through the visible lines and then the vertical blanking lines, and wraps at the end of each frame.

A 16-bit status word gives software the blanking and line-match flags. It also holds three interrupt enables and an 8-bit line compare value. The block emits single-cycle interrupt requests to an external interrupt controller. It also emits single-cycle start pulses to DMA channels that are armed for horizontal or vertical blank, and a frame-done pulse.

The defaults give 960 active and 272 blank cycles per line, with 160 visible lines out of 228. Every count is a parameter, so a reduced geometry can be built for test.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst_ni` is low and directly after its release, `line_o` is 0, `status_o` is 0x0000 and every pulse output is 0.
- R2: A line lasts ACTIVE_CYC+BLANK_CYC cycles. The hblank flag (status bit 1) becomes 1 once ACTIVE_CYC cycles of the line have elapsed, and returns to 0 in the cycle the line counter advances.
- R3: `line_o` counts 0 to TOTAL_LINES-1 and then wraps to 0. `frame_done_o` pulses in exactly the cycle in which `line_o` first reads 0 after the wrap.
- R4: The vblank flag (status bit 0) is set when the line counter reaches VIS_LINES and cleared when it wraps to 0. On entry to VIS_LINES, `dma_vblank_o` pulses unconditionally, and `irq_vblank_o` pulses if the vblank enable (status bit 3) is 1.
- R5: `irq_hblank_o` pulses at every hblank entry, including lines inside vertical blank, whenever the hblank enable (status bit 4) is 1.
- R6: `dma_hblank_o` pulses at hblank entry only on lines 0 to VIS_LINES-1, whatever the interrupt enables are.
- R7: At every line change, the match flag (status bit 2) is set to 1 if the new line equals the compare byte (status bits 15:8) and is set to 0 otherwise. `irq_line_o` pulses on a match if the match enable (status bit 5) is 1. Compare 0 matches on the wrap.
- R8: A write updates only status bits 15:8 and 5:3. Bits 2:0 come from the timing alone, and bits 7:6 always read 0.
- R9: Every interrupt and DMA pulse lasts one cycle. It appears in the same cycle in which the flag or counter that causes it first shows its new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 16 | Status write data |
| status_o | output | 16 | Status word: compare, enables, flags |
| line_o | output | $clog2(TOTAL_LINES) | Current line number |
| irq_vblank_o | output | 1 | Vblank interrupt request pulse |
| irq_hblank_o | output | 1 | Hblank interrupt request pulse |
| irq_line_o | output | 1 | Line-match interrupt request pulse |
| dma_hblank_o | output | 1 | Hblank DMA start pulse |
| dma_vblank_o | output | 1 | Vblank DMA start pulse |
| frame_done_o | output | 1 | One pulse per frame at the line wrap |

## Verification
The hardest cases are the overlaps inside vertical blank. There, hblank interrupts must keep firing while hblank DMA must stay silent, and a compare value that points into the blanking region or at line 0 must still raise the match. The bench builds the block with a reduced geometry of 12-cycle lines and 10 lines per frame, so that several frames fit in a short run. It then moves the compare byte to line 9 and then to line 0 between frames, and turns the enables off, so that the DMA pulses can be seen to continue without any interrupts.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int ST_VBL      = 0;
  localparam int ST_HBL      = 1;
  localparam int ST_MATCH    = 2;
  localparam int ST_VBL_IE   = 3;
  localparam int ST_HBL_IE   = 4;
  localparam int ST_MATCH_IE = 5;
  localparam int CMP_LSB     = 8;
  localparam int CMP_W       = 8;

  typedef struct packed {
    logic hbl_entry;
    logic line_adv;
    logic vbl_entry;
    logic frame_wrap;
    logic visible;
    logic match;
  } raster_evt_t;
endpackage

// File: rtl/raster_dot_ctr.sv
module raster_dot_ctr #(
  parameter int ACTIVE_CYC = 960,
  parameter int BLANK_CYC  = 272
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic hbl_entry_o,
  output logic line_end_o
);
  localparam int LINE_CYC = ACTIVE_CYC + BLANK_CYC;
  localparam int DOT_W    = $clog2(LINE_CYC);
  localparam logic [DOT_W-1:0] ACT_LAST  = DOT_W'(ACTIVE_CYC - 1);
  localparam logic [DOT_W-1:0] LINE_LAST = DOT_W'(LINE_CYC - 1);

  logic [DOT_W-1:0] dot_q;

  assign hbl_entry_o = (dot_q == ACT_LAST);
  assign line_end_o  = (dot_q == LINE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         dot_q <= '0;
    else if (line_end_o) dot_q <= '0;
    else                 dot_q <= dot_q + 1'b1;
  end
endmodule

// File: rtl/raster_line_ctr.sv
module raster_line_ctr #(
  parameter int VIS_LINES   = 160,
  parameter int TOTAL_LINES = 228,
  localparam int LINE_W     = $clog2(TOTAL_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [7:0]        cmp_i,
  output logic [LINE_W-1:0] line_o,
  output logic              visible_o,
  output logic              vbl_entry_o,
  output logic              wrap_o,
  output logic              match_o
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES - 1);
  localparam logic [LINE_W-1:0] VBL_LINE  = LINE_W'(VIS_LINES);

  logic [LINE_W-1:0] line_q, line_d;

  always_comb begin
    line_d = (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
  end

  assign line_o      = line_q;
  assign visible_o   = (line_q < VBL_LINE);
  assign vbl_entry_o = adv_i && (line_d == VBL_LINE);
  assign wrap_o      = adv_i && (line_q == LAST_LINE);
  assign match_o     = (8'(line_d) == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    line_q <= '0;
    else if (adv_i) line_q <= line_d;
  end
endmodule

// File: rtl/raster_status.sv
module raster_status
  import raster_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  raster_evt_t evt_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [7:0]  cmp_o,
  output logic [15:0] status_o,
  output logic        irq_vblank_o,
  output logic        irq_hblank_o,
  output logic        irq_line_o,
  output logic        dma_hblank_o,
  output logic        dma_vblank_o,
  output logic        frame_done_o
);
  logic [2:0]       flag_q;
  logic [2:0]       ie_q;
  logic [CMP_W-1:0] cmp_q;
  logic [5:0]       pulse_q;

  // flags follow timing events only; software reaches enables and compare
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= '0;
      ie_q    <= '0;
      cmp_q   <= '0;
      pulse_q <= '0;
    end else begin
      pulse_q <= '0;
      if (evt_i.hbl_entry) begin
        flag_q[ST_HBL] <= 1'b1;
        pulse_q[0]     <= ie_q[ST_HBL_IE-3];
        pulse_q[3]     <= evt_i.visible;
      end
      if (evt_i.line_adv) begin
        flag_q[ST_HBL]   <= 1'b0;
        flag_q[ST_MATCH] <= evt_i.match;
        pulse_q[2]       <= evt_i.match && ie_q[ST_MATCH_IE-3];
        if (evt_i.vbl_entry) begin
          flag_q[ST_VBL] <= 1'b1;
          pulse_q[1]     <= ie_q[ST_VBL_IE-3];
          pulse_q[4]     <= 1'b1;
        end
        if (evt_i.frame_wrap) begin
          flag_q[ST_VBL] <= 1'b0;
          pulse_q[5]     <= 1'b1;
        end
      end
      if (wr_en_i) begin
        ie_q  <= wr_data_i[ST_MATCH_IE:ST_VBL_IE];
        cmp_q <= wr_data_i[CMP_LSB+CMP_W-1:CMP_LSB];
      end
    end
  end

  assign cmp_o        = cmp_q;
  assign status_o     = {cmp_q, 2'b00, ie_q, flag_q};
  assign irq_hblank_o = pulse_q[0];
  assign irq_vblank_o = pulse_q[1];
  assign irq_line_o   = pulse_q[2];
  assign dma_hblank_o = pulse_q[3];
  assign dma_vblank_o = pulse_q[4];
  assign frame_done_o = pulse_q[5];
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int ACTIVE_CYC  = 960,
  parameter int BLANK_CYC   = 272,
  parameter int VIS_LINES   = 160,
  parameter int TOTAL_LINES = 228
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [15:0]                    wr_data_i,
  output logic [15:0]                    status_o,
  output logic [$clog2(TOTAL_LINES)-1:0] line_o,
  output logic                           irq_vblank_o,
  output logic                           irq_hblank_o,
  output logic                           irq_line_o,
  output logic                           dma_hblank_o,
  output logic                           dma_vblank_o,
  output logic                           frame_done_o
);
  raster_evt_t evt;
  logic [7:0]  cmp;

  raster_dot_ctr #(.ACTIVE_CYC(ACTIVE_CYC), .BLANK_CYC(BLANK_CYC)) u_dot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hbl_entry_o (evt.hbl_entry),
    .line_end_o  (evt.line_adv)
  );

  raster_line_ctr #(.VIS_LINES(VIS_LINES), .TOTAL_LINES(TOTAL_LINES)) u_line (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (evt.line_adv),
    .cmp_i       (cmp),
    .line_o      (line_o),
    .visible_o   (evt.visible),
    .vbl_entry_o (evt.vbl_entry),
    .wrap_o      (evt.frame_wrap),
    .match_o     (evt.match)
  );

  raster_status u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .cmp_o        (cmp),
    .status_o     (status_o),
    .irq_vblank_o (irq_vblank_o),
    .irq_hblank_o (irq_hblank_o),
    .irq_line_o   (irq_line_o),
    .dma_hblank_o (dma_hblank_o),
    .dma_vblank_o (dma_vblank_o),
    .frame_done_o (frame_done_o)
  );
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int VIS_LINES   = 160,
  parameter int TOTAL_LINES = 228
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           wr_en_i,
  input logic [15:0]                    wr_data_i,
  input logic [15:0]                    status_o,
  input logic [$clog2(TOTAL_LINES)-1:0] line_o,
  input logic                           irq_vblank_o,
  input logic                           irq_hblank_o,
  input logic                           irq_line_o,
  input logic                           dma_hblank_o,
  input logic                           dma_vblank_o,
  input logic                           frame_done_o
);
  localparam int LW = $clog2(TOTAL_LINES);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;

  assert_line_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(line_o) < TOTAL_LINES);

  assert_frame_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_o && started_q) |-> (line_o == '0 && $past(line_o) == LW'(TOTAL_LINES - 1)));

  assert_vblank_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_vblank_o |-> (status_o[0] && line_o == LW'(VIS_LINES)));

  assert_hblank_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_hblank_o && started_q) |-> ($rose(status_o[1]) && $past(status_o[4])));

  assert_hblank_dma_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_hblank_o |-> (status_o[1] && 32'(line_o) < VIS_LINES));

  assert_match_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_line_o && started_q) |-> (status_o[2] && $past(status_o[5]) && line_o == LW'(status_o[15:8])));

  assert_pad_bits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:6] == 2'b00);

  assert_vbl_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_vblank_o |=> !dma_vblank_o);

  assert_hbl_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_hblank_o |=> !dma_hblank_o);

  logic unused;
  assign unused = wr_en_i ^ (^wr_data_i);
endmodule

bind raster_timing_gen raster_timing_chk #(
  .VIS_LINES(VIS_LINES), .TOTAL_LINES(TOTAL_LINES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .status_o(status_o), .line_o(line_o), .irq_vblank_o(irq_vblank_o),
  .irq_hblank_o(irq_hblank_o), .irq_line_o(irq_line_o),
  .dma_hblank_o(dma_hblank_o), .dma_vblank_o(dma_vblank_o),
  .frame_done_o(frame_done_o)
);

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
  localparam int ACT = 8, BLK = 4, VIS = 6, TOT = 10;

  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] status;
  logic [3:0]  line;
  logic        irq_v, irq_h, irq_l, dma_h, dma_v, fdone;
  int          k, n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  raster_timing_gen #(.ACTIVE_CYC(ACT), .BLANK_CYC(BLK), .VIS_LINES(VIS), .TOTAL_LINES(TOT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .status_o(status), .line_o(line), .irq_vblank_o(irq_v), .irq_hblank_o(irq_h),
    .irq_line_o(irq_l), .dma_hblank_o(dma_h), .dma_vblank_o(dma_v), .frame_done_o(fdone)
  );

  // edges since reset release
  always @(posedge clk or negedge rst_n)
    if (!rst_n) k <= 0; else k <= k + 1;

  // pulse order: {frame, dma_v, dma_h, irq_l, irq_v, irq_h}
  typedef struct packed {
    logic [15:0] cyc;
    logic [3:0]  ln;
    logic [2:0]  flg;
    logic [5:0]  pls;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{16'd1,   4'd0, 3'b000, 6'b000000},  // R8
    '{16'd8,   4'd0, 3'b010, 6'b001001},  // R2 R5 R6
    '{16'd9,   4'd0, 3'b010, 6'b000000},  // R9
    '{16'd12,  4'd1, 3'b000, 6'b000000},  // R2
    '{16'd36,  4'd3, 3'b100, 6'b000100},  // R7
    '{16'd44,  4'd3, 3'b110, 6'b001001},  // R6
    '{16'd48,  4'd4, 3'b000, 6'b000000},  // R7
    '{16'd72,  4'd6, 3'b001, 6'b010010},  // R4
    '{16'd80,  4'd6, 3'b011, 6'b000001},  // R5 R6
    '{16'd84,  4'd7, 3'b001, 6'b000000},  // R9
    '{16'd116, 4'd9, 3'b011, 6'b000001},  // R5
    '{16'd120, 4'd0, 3'b000, 6'b100000},  // R3 R4
    '{16'd121, 4'd0, 3'b000, 6'b000000},  // R9
    '{16'd156, 4'd3, 3'b100, 6'b000100}   // R7
  };

  function automatic logic [5:0] pulses();
    return {fdone, dma_v, dma_h, irq_l, irq_v, irq_h};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at k=%0d actual=%h expected=%h", req, k, act, exp);
    end
  endtask

  task automatic go(int t);
    while (k < t) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic probe(string req, int t, logic [3:0] ln, logic [15:0] st, logic [5:0] pl);
    go(t);
    chk({req, " line"}, 32'(line), 32'(ln));
    chk({req, " status"}, 32'(status), 32'(st));
    chk({req, " pulses"}, 32'(pulses()), 32'(pl));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 line", 32'(line), 0);
    chk("R1 status", 32'(status), 0);
    chk("R1 pulses", 32'(pulses()), 0);
    rst_n = 1;
    // flag and pad bits in the write must not land (R8)
    wr(16'h03FF);
    for (int i = 0; i < 14; i++) begin
      go(int'(VEC[i].cyc));
      chk("R2-table line", 32'(line), 32'(VEC[i].ln));
      chk("R8 status", 32'(status), 32'({8'h03, 8'h38} | 16'(VEC[i].flg)));
      chk("R9 pulses", 32'(pulses()), 32'(VEC[i].pls));
    end
    // enables off: DMA continues, interrupts stop
    go(160); wr(16'h0300);
    probe("R7 no-irq", 276, 4'd3, 16'h0304, 6'b000000);
    probe("R6 dma-no-irq", 284, 4'd3, 16'h0306, 6'b001000);
    probe("R4 dma-no-irq", 312, 4'd6, 16'h0301, 6'b010000);
    // compare inside vblank
    go(320); wr(16'h0920);
    probe("R7 vblank-match", 348, 4'd9, 16'h0925, 6'b000100);
    // compare 0 matches on the wrap
    go(350); wr(16'h0020);
    probe("R7 wrap-match R3", 360, 4'd0, 16'h0024, 6'b100100);
    // reset mid-run
    go(365);
    rst_n = 0; #1;
    chk("R1 mid line", 32'(line), 0);
    chk("R1 mid status", 32'(status), 0);
    chk("R1 mid pulses", 32'(pulses()), 0);
    @(negedge clk); rst_n = 1;
    probe("R6 post-reset", 8, 4'd0, 16'h0002, 6'b001000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule